// File: doc/BRIEF.md
# Camera Strobe and Shutter Sequencer

This block drives three timed control lines toward a camera module: a prestrobe line, a strobe line and a shutter line. Each line belongs to its own channel. A channel runs a three-stage chain. It first skips a programmed number of whole frames, then waits a programmed number of counting ticks, and then holds its line active for a programmed number of ticks. When the active phase ends, the channel clears its own enable bit, so one enable write buys exactly one pulse.

Every channel starts its chain on one common frame-start trigger. The trigger is the rising edge of a global-reset level. A selector takes that level either from an external input or from a one-cycle internal pulse that software fires. The chosen level is also driven out as the camera's global-reset line. End-of-frame events are the falling edges of the parallel sensor's vertical sync input. The counting ticks come from an internal divider of the system clock.

Software programs the block through a plain write strobe with an address and a data word. All other pins are plain control and status levels. No pin carries a data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `cam_strobe_seq`

## Requirements
- R1: A rising edge of the selected global-reset level arms every channel whose enable is set and which is idle. At arming the channel loads its frame, delay and length values, and its busy bit is high in the next cycle. A trigger that reaches a busy channel is ignored.
- R2: With a frame value N above 0, the channel leaves its line inactive until N falling edges of `vsync_i` have been seen after arming. Rising edges of `vsync_i` do not count. A frame value of 0 skips this stage.
- R3: The delay stage lasts D counting ticks. With a tick every cycle, the line turns active D cycles after the arming edge. A delay of 0 makes the line active in the cycle right after arming, or right after the last counted frame.
- R4: The line stays active for exactly L counting ticks. It then turns inactive, and in that same cycle the channel's enable bit and busy bit both drop.
- R5: A length of 0 means the line never turns active. The enable bit is cleared in the cycle after the arming edge, and busy never rises.
- R6: A write to a channel's frame, delay or length register during a running sequence does not change that sequence. The new value is used from the next arming.
- R7: Bit 0 of the control register (address 0) selects the trigger source: 0 takes `ext_greset_i`, 1 takes the internal pulse. Writing 1 to bit 0 at address 3 produces a one-cycle internal pulse. The source that is not selected has no effect, and `greset_o` follows the selected level.
- R8: Writing a 1 to bit c of address 2 sets the enable of channel c (0 is prestrobe, 1 is strobe, 2 is shutter). A 0 bit leaves the enable unchanged. Only the end of a pulse (R4) or a zero-length arming (R5) clears an enable.
- R9: Each line is active high by default. Control bit 1 inverts both the prestrobe and the strobe lines. Control bit 2 inverts the shutter line. Control bit 3 inverts `greset_o`.
- R10: Address 1 holds the tick divisor. A divisor of 0 stops all ticks, and running delay and length stages then hold. A divisor of N above 0 gives one tick every N cycles. A write to address 1 restarts the divider phase.
- R11: A channel whose enable is clear ignores the trigger and stays idle.
- R12: Channel c's registers sit at 4·(c+1) for the frame count, 4·(c+1)+1 for the delay and 4·(c+1)+2 for the length. Each register takes the low bits of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| ext_greset_i | input | 1 | External global-reset level, active high |
| vsync_i | input | 1 | Vertical sync from the parallel sensor |
| prestrobe_o | output | 1 | Prestrobe control line |
| strobe_o | output | 1 | Strobe control line |
| shutter_o | output | 1 | Shutter control line |
| greset_o | output | 1 | Global-reset line to the camera |
| ch_en_o | output | 3 | Channel enable bits |
| ch_busy_o | output | 3 | Channel busy bits, high from arming until the pulse ends |

## Verification
The bench builds the block with 8-bit delay and length counters, 4-bit frame counters and a 4-bit divisor. At these widths every stage of the chain finishes in a few dozen cycles. A divisor of 1 ticks every cycle, which makes the delay and width of each pulse exact to the cycle. Divisors of 3 and 0 show that the stages scale with the tick period and that they stall when the ticks stop. Short frame counts, reprogramming while a pulse runs, and source switching then all fit in one short directed run.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAMES,
    ST_DELAY,
    ST_ACTIVE
  } seq_state_e;

  localparam int NUM_CH = 3;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_DIV    = 1;
  localparam int ADDR_ENSET  = 2;
  localparam int ADDR_SWTRIG = 3;

  localparam int CH_STRIDE   = 4;
  localparam int OFF_FRAMES  = 0;
  localparam int OFF_DELAY   = 1;
  localparam int OFF_LENGTH  = 2;

  localparam int CTRL_SRC_INT  = 0;
  localparam int CTRL_POL_STRB = 1;
  localparam int CTRL_POL_SHUT = 2;
  localparam int CTRL_POL_GRST = 3;

endpackage

// File: rtl/cam_seq_tick_div.sv
module cam_seq_tick_div #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last_phase;

  assign last_phase = div_i - DIV_W'(1);
  assign tick_o     = (div_i != '0) && (phase_q >= last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart_i || div_i == '0) begin
      phase_q <= '0;
    end else if (phase_q >= last_phase) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + DIV_W'(1);
    end
  end

  // two ticks never land on adjacent cycles when the divisor exceeds one
  assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i > DIV_W'(1) && !restart_i) |=> !tick_o);

endmodule

// File: rtl/cam_seq_trig.sv
module cam_seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic src_int_i,
  input  logic sw_fire_i,
  input  logic ext_i,
  input  logic vsync_i,
  input  logic pol_i,
  output logic trig_o,
  output logic eof_o,
  output logic greset_o
);

  logic int_pulse_q;
  logic src_level;
  logic src_prev_q;
  logic vsync_prev_q;

  assign src_level = src_int_i ? int_pulse_q : ext_i;
  assign trig_o    = src_level & ~src_prev_q;
  assign eof_o     = vsync_prev_q & ~vsync_i;
  assign greset_o  = src_level ^ pol_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_pulse_q  <= 1'b0;
      src_prev_q   <= 1'b0;
      vsync_prev_q <= 1'b0;
    end else begin
      int_pulse_q  <= sw_fire_i;
      src_prev_q   <= src_level;
      vsync_prev_q <= vsync_i;
    end
  end

  // only a falling vsync edge may produce an end-of-frame event
  assert_eof_falling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (!vsync_i && $past(vsync_i)));

  // a trigger is one cycle wide
  assert_trig_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

endmodule

// File: rtl/cam_seq_channel.sv
module cam_seq_channel
  import cam_seq_pkg::*;
#(
  parameter int FRM_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic             eof_i,
  input  logic             tick_i,
  input  logic [FRM_W-1:0] frames_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o,
  output logic             busy_o,
  output logic             done_o
);

  seq_state_e       state_q;
  logic [FRM_W-1:0] frm_q;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] len_q;
  logic             arm;
  logic             zero_len;
  logic             pulse_end;

  assign arm       = trig_i && en_i && (state_q == ST_IDLE);
  assign zero_len  = (len_i == '0);
  assign pulse_end = (state_q == ST_ACTIVE) && tick_i && (len_q == CNT_W'(1));
  assign done_o    = (arm && zero_len) || pulse_end;
  assign active_o  = (state_q == ST_ACTIVE);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frm_q   <= '0;
      dly_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arm && !zero_len) begin
            frm_q <= frames_i;
            dly_q <= delay_i;
            len_q <= len_i;
            if (frames_i != '0)     state_q <= ST_FRAMES;
            else if (delay_i != '0) state_q <= ST_DELAY;
            else                    state_q <= ST_ACTIVE;
          end
        end
        ST_FRAMES: begin
          if (eof_i) begin
            if (frm_q == FRM_W'(1)) begin
              state_q <= (dly_q != '0) ? ST_DELAY : ST_ACTIVE;
            end else begin
              frm_q <= frm_q - FRM_W'(1);
            end
          end
        end
        ST_DELAY: begin
          if (tick_i) begin
            if (dly_q == CNT_W'(1)) state_q <= ST_ACTIVE;
            else                    dly_q   <= dly_q - CNT_W'(1);
          end
        end
        ST_ACTIVE: begin
          if (tick_i) begin
            if (len_q == CNT_W'(1)) state_q <= ST_IDLE;
            else                    len_q   <= len_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_arm_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && en_i && !busy_o && len_i != '0) |=> busy_o);

  assert_zero_len_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && en_i && !busy_o && len_i == '0) |=> !busy_o);

  assert_frame_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAMES && !eof_i) |=> (state_q == ST_FRAMES && $stable(frm_q)));

  assert_delay_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELAY && !tick_i) |=> (state_q == ST_DELAY && $stable(dly_q)));

  assert_len_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !tick_i) |=> active_o);

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !en_i) |=> !busy_o);

endmodule

// File: rtl/cam_strobe_seq.sv
module cam_strobe_seq
  import cam_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int FRM_W  = 8,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_greset_i,
  input  logic              vsync_i,
  output logic              prestrobe_o,
  output logic              strobe_o,
  output logic              shutter_o,
  output logic              greset_o,
  output logic [2:0]        ch_en_o,
  output logic [2:0]        ch_busy_o
);

  localparam int NCH = NUM_CH;

  logic             src_int_q;
  logic             pol_strb_q;
  logic             pol_shut_q;
  logic             pol_grst_q;
  logic [DIV_W-1:0] div_q;
  logic [NCH-1:0]   en_q;
  logic [NCH-1:0]   en_set;
  logic [NCH-1:0]   done;
  logic [NCH-1:0]   active;
  logic [NCH-1:0]   busy;
  logic [FRM_W-1:0] frames_q [NCH];
  logic [CNT_W-1:0] delay_q  [NCH];
  logic [CNT_W-1:0] len_q    [NCH];
  logic             wr_ctrl;
  logic             wr_div;
  logic             sw_fire;
  logic             trig;
  logic             eof;
  logic             tick;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign wr_div  = wr_en && (wr_addr == ADDR_W'(ADDR_DIV));
  assign sw_fire = wr_en && (wr_addr == ADDR_W'(ADDR_SWTRIG)) && wr_data[0];
  assign en_set  = (wr_en && wr_addr == ADDR_W'(ADDR_ENSET)) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_int_q  <= 1'b0;
      pol_strb_q <= 1'b0;
      pol_shut_q <= 1'b0;
      pol_grst_q <= 1'b0;
      div_q      <= '0;
      en_q       <= '0;
    end else begin
      if (wr_ctrl) begin
        src_int_q  <= wr_data[CTRL_SRC_INT];
        pol_strb_q <= wr_data[CTRL_POL_STRB];
        pol_shut_q <= wr_data[CTRL_POL_SHUT];
        pol_grst_q <= wr_data[CTRL_POL_GRST];
      end
      if (wr_div) div_q <= wr_data[DIV_W-1:0];
      en_q <= (en_q & ~done) | en_set;
    end
  end

  cam_seq_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_i     (div_q),
    .restart_i (wr_div),
    .tick_o    (tick)
  );

  cam_seq_trig u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_int_i (src_int_q),
    .sw_fire_i (sw_fire),
    .ext_i     (ext_greset_i),
    .vsync_i   (vsync_i),
    .pol_i     (pol_grst_q),
    .trig_o    (trig),
    .eof_o     (eof),
    .greset_o  (greset_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = CH_STRIDE * (c + 1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        frames_q[c] <= '0;
        delay_q[c]  <= '0;
        len_q[c]    <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(BASE + OFF_FRAMES)) frames_q[c] <= wr_data[FRM_W-1:0];
        if (wr_addr == ADDR_W'(BASE + OFF_DELAY))  delay_q[c]  <= wr_data[CNT_W-1:0];
        if (wr_addr == ADDR_W'(BASE + OFF_LENGTH)) len_q[c]    <= wr_data[CNT_W-1:0];
      end
    end

    cam_seq_channel #(.FRM_W(FRM_W), .CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_q[c]),
      .trig_i   (trig),
      .eof_i    (eof),
      .tick_i   (tick),
      .frames_i (frames_q[c]),
      .delay_i  (delay_q[c]),
      .len_i    (len_q[c]),
      .active_o (active[c]),
      .busy_o   (busy[c]),
      .done_o   (done[c])
    );

    // an enable only falls when its channel finished a pulse or armed with zero length
    assert_en_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[c]) |-> $past(done[c]));

    // a running pulse never outlives its enable
    assert_active_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[c]) |-> !en_q[c] || $past(en_set[c]));
  end

  assign prestrobe_o = active[0] ^ pol_strb_q;
  assign strobe_o    = active[1] ^ pol_strb_q;
  assign shutter_o   = active[2] ^ pol_shut_q;
  assign ch_en_o     = en_q;
  assign ch_busy_o   = busy;

endmodule

// File: tb/sim_cam_strobe_seq.sv
module sim_cam_strobe_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              ext_greset_i = 1'b0;
  logic              vsync_i = 1'b0;
  logic              prestrobe_o, strobe_o, shutter_o, greset_o;
  logic [2:0]        ch_en_o, ch_busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_strobe_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRM_W(4), .CNT_W(8), .DIV_W(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_greset_i(ext_greset_i), .vsync_i(vsync_i),
    .prestrobe_o(prestrobe_o), .strobe_o(strobe_o), .shutter_o(shutter_o),
    .greset_o(greset_o), .ch_en_o(ch_en_o), .ch_busy_o(ch_busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int ch, input int f, input int d, input int l);
    wr(4*(ch+1)+0, f);
    wr(4*(ch+1)+1, d);
    wr(4*(ch+1)+2, l);
  endtask

  task automatic fire_ext();
    @(negedge clk); ext_greset_i = 1'b1;
    @(negedge clk); ext_greset_i = 1'b0;
  endtask

  function automatic logic line(input int ch);
    case (ch)
      0: return prestrobe_o;
      1: return strobe_o;
      default: return shutter_o;
    endcase
  endfunction

  task automatic measure(input int ch, output int wait_n, output int width);
    wait_n = 0; width = 0;
    while (!line(ch) && wait_n < 200) begin wait_n++; @(negedge clk); end
    while (line(ch) && width < 200) begin width++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk(prestrobe_o == 0 && strobe_o == 0 && shutter_o == 0, "R9 reset lines", int'(shutter_o), 0);
    chk(greset_o == 0, "R9 reset greset", int'(greset_o), 0);
    chk(ch_en_o == 0, "R8 reset enables", int'(ch_en_o), 0);
    chk(ch_busy_o == 0, "R1 reset busy", int'(ch_busy_o), 0);
  endtask

  task automatic t_basic();
    int w, wd;
    wr(1, 1);
    cfg(0, 0, 3, 4);
    wr(2, 1);
    chk(ch_en_o == 3'b001, "R8 enable set", int'(ch_en_o), 1);
    fire_ext();
    chk(ch_busy_o[0] == 1, "R1 busy after arm", int'(ch_busy_o[0]), 1);
    measure(0, w, wd);
    chk(w == 3, "R3 delay cycles", w, 3);
    chk(wd == 4, "R4 pulse width", wd, 4);
    chk(ch_en_o[0] == 0 && ch_busy_o[0] == 0, "R4 enable and busy cleared", int'(ch_en_o[0]), 0);
  endtask

  task automatic t_delay0();
    int w, wd;
    cfg(1, 0, 0, 2);
    wr(2, 2);
    fire_ext();
    measure(1, w, wd);
    chk(w == 0, "R3 zero delay", w, 0);
    chk(wd == 2, "R4 width zero delay", wd, 2);
  endtask

  task automatic t_len0();
    int seen = 0;
    cfg(2, 0, 5, 0);
    wr(2, 4);
    fire_ext();
    chk(ch_en_o[2] == 0, "R5 enable cleared at once", int'(ch_en_o[2]), 0);
    chk(ch_busy_o[2] == 0, "R5 never busy", int'(ch_busy_o[2]), 0);
    for (int i = 0; i < 12; i++) begin
      if (shutter_o) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R5 line never active", seen, 0);
  endtask

  task automatic t_frames();
    int w, wd;
    cfg(2, 2, 0, 1);
    wr(2, 4);
    fire_ext();
    vsync_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(shutter_o == 0 && ch_busy_o[2] == 1, "R2 rising edge not counted", int'(shutter_o), 0);
    vsync_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(shutter_o == 0 && ch_busy_o[2] == 1, "R2 one frame skipped", int'(shutter_o), 0);
    vsync_i = 1'b1;
    repeat (2) @(negedge clk);
    vsync_i = 1'b0;
    @(negedge clk);
    measure(2, w, wd);
    chk(w == 0, "R2 active after second frame end", w, 0);
    chk(wd == 1, "R2 width after frames", wd, 1);
  endtask

  task automatic t_rewrite();
    int w, wd;
    cfg(0, 0, 5, 3);
    wr(2, 1);
    fire_ext();
    wr(2 + 4, 8);
    fire_ext();
    measure(0, w, wd);
    chk(w == 1, "R1 retrigger while busy ignored", w, 1);
    chk(wd == 3, "R6 running length unchanged", wd, 3);
    wr(2, 1);
    fire_ext();
    measure(0, w, wd);
    chk(w == 5 && wd == 8, "R6 new length at next arming", wd, 8);
  endtask

  task automatic t_disabled();
    fire_ext();
    chk(ch_busy_o == 0, "R11 disabled channels stay idle", int'(ch_busy_o), 0);
    repeat (8) @(negedge clk);
    chk(prestrobe_o == 0 && strobe_o == 0 && shutter_o == 0, "R11 lines stay inactive", 0, 0);
  endtask

  task automatic t_src();
    int w, wd;
    wr(0, 1);
    cfg(0, 0, 2, 2);
    wr(2, 1);
    fire_ext();
    chk(ch_busy_o[0] == 0, "R7 unselected external ignored", int'(ch_busy_o[0]), 0);
    wr(3, 1);
    chk(greset_o == 1, "R7 greset follows internal pulse", int'(greset_o), 1);
    @(negedge clk);
    chk(ch_busy_o[0] == 1, "R7 internal trigger arms", int'(ch_busy_o[0]), 1);
    measure(0, w, wd);
    chk(w == 2 && wd == 2, "R7 internal sequence timing", w * 10 + wd, 22);
    wr(0, 0);
  endtask

  task automatic t_pol();
    wr(0, 14);
    chk(prestrobe_o == 1 && strobe_o == 1, "R9 strobe pair inverted", int'(strobe_o), 1);
    chk(shutter_o == 1, "R9 shutter inverted", int'(shutter_o), 1);
    chk(greset_o == 1, "R9 greset inverted", int'(greset_o), 1);
    wr(0, 4);
    chk(prestrobe_o == 0 && shutter_o == 1 && greset_o == 0, "R9 independent polarity", int'(prestrobe_o), 0);
    wr(0, 0);
  endtask

  task automatic t_div();
    int w, wd;
    wr(1, 3);
    cfg(0, 0, 1, 2);
    wr(2, 1);
    fire_ext();
    measure(0, w, wd);
    chk(wd == 6, "R10 width scales with divisor", wd, 6);
    chk(w >= 1 && w <= 3, "R10 delay within one period", w, 3);
    wr(1, 0);
    cfg(0, 0, 2, 2);
    wr(2, 1);
    fire_ext();
    repeat (20) @(negedge clk);
    chk(ch_busy_o[0] == 1 && prestrobe_o == 0, "R10 zero divisor stalls", int'(prestrobe_o), 0);
    wr(1, 1);
    measure(0, w, wd);
    chk(wd == 2, "R10 resumes after divisor write", wd, 2);
  endtask

  task automatic t_en_keep();
    wr(2, 2);
    wr(2, 0);
    chk(ch_en_o[1] == 1, "R8 writing zero keeps enable", int'(ch_en_o[1]), 1);
    cfg(1, 0, 0, 0);
    chk(ch_en_o[1] == 1, "R12 config write leaves enable", int'(ch_en_o[1]), 1);
    fire_ext();
    chk(ch_en_o[1] == 0, "R8 cleared by zero-length arming", int'(ch_en_o[1]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_delay0();
    t_len0();
    t_frames();
    t_rewrite();
    t_disabled();
    t_src();
    t_pol();
    t_div();
    t_en_keep();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule